// File: doc/BRIEF.md
# Scoreboard Issue Hazard Checker

This block sits at the issue stage of a pipeline that has several functional units with different latencies. It keeps one status row for each unit in flight: one integer unit, one memory unit, three adders, two multipliers and one divider. Each row records whether the unit is occupied, the operation code, the destination register and both source registers. A decoded instruction arrives with a valid bit, a unit class and three register indices. Within the same cycle the block decides whether that instruction may be dispatched, which unit row receives it, and, if it is held back, why.

Hazards are found by searching the table column by column. The destination column is searched for the new sources (read-after-write) and for the new destination (write-after-write). The source columns are searched for the new destination (write-after-read). The busy column is searched for a free unit of the requested class. A small per-row countdown predicts the cycle in which each result reaches the single write-back port, so that an instruction whose result would arrive in that same cycle is refused. Write-back reports completion with one pulse per row. A pulse frees its row in time for the same cycle's search, so the freed row can be reissued at once.

Top module: `sb_issue_ctl`

## Requirements
- R1: While `in_valid` is low, `issue_grant` is 0 and `stall_why` is 0 (none). Reset empties every row.
- R2: Class codes map to rows: 0 integer→row 0, 1 memory→row 1, 2 add→rows 2..4, 3 multiply→rows 5..6, 4 divide→row 7. A grant picks the lowest-numbered free row of the class and reports its index on `issue_row`.
- R3: If no row of the requested class is free, there is no grant and `stall_why` = 1 (unit busy). Class codes 5..7 have no rows and always stall with code 1.
- R4: A nonzero source that equals the destination of any occupied row stalls issue with `stall_why` = 2 (read-after-write).
- R5: A nonzero destination that equals either source of any occupied row stalls issue with `stall_why` = 4 (write-after-read).
- R6: A nonzero destination that equals the destination of any occupied row stalls issue with `stall_why` = 3 (write-after-write). When several reasons apply, the reported one follows the priority 1 > 2 > 3 > 4 > 5.
- R7: Register index 0 never matches anything, in any field.
- R8: A `wb_done` pulse for an occupied row frees it at the next edge. In the same cycle it already counts as free for every check, so the row can be reissued in that cycle. Pulses for idle rows have no effect.
- R9: Latencies are integer 1, memory 1, add 1, multiply 3 and divide 4 cycles. An instruction with latency L stalls with `stall_why` = 5 (write-back port) when an occupied row is due to write back exactly L cycles after the present one.
- R10: A granted instruction's row is occupied from the next cycle on, holds the operation and registers it was given, and stays occupied until its `wb_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is waiting at issue |
| in_cls | input | 3 | Requested unit class code |
| in_op | input | 6 | Operation code stored in the row |
| in_dst | input | 5 | Destination register index (0 = none) |
| in_src1 | input | 5 | First source register index (0 = none) |
| in_src2 | input | 5 | Second source register index (0 = none) |
| wb_done | input | 8 | Per-row write-back completion pulses |
| issue_grant | output | 1 | The waiting instruction is dispatched in this cycle |
| issue_row | output | 3 | Row that receives the dispatched instruction |
| stall_why | output | 3 | Stall reason: 0 none, 1 unit, 2 RAW, 3 WAW, 4 WAR, 5 write-back port |

## Verification
A row whose stored fields are corrupted, or that keeps its busy bit too long, shows up on the very next issue attempt that touches it. That attempt either stalls with a reason code that no register overlap explains, or reports a free class as busy. A row freed too early appears as a grant in a cycle where a hazard should have held the instruction back. A countdown that is off by one shifts a write-back-port stall by one cycle, so the bench probes each countdown in the cycle of the predicted collision and again in the cycle just after it.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int REG_W    = 5;
    localparam int OP_W     = 6;
    localparam int CLS_W    = 3;

    localparam int N_INT    = 1;
    localparam int N_MEM    = 1;
    localparam int N_ADD    = 3;
    localparam int N_MUL    = 2;
    localparam int N_DIV    = 1;

    localparam int BASE_INT = 0;
    localparam int BASE_MEM = BASE_INT + N_INT;
    localparam int BASE_ADD = BASE_MEM + N_MEM;
    localparam int BASE_MUL = BASE_ADD + N_ADD;
    localparam int BASE_DIV = BASE_MUL + N_MUL;
    localparam int NUM_ROWS = BASE_DIV + N_DIV;
    localparam int ROW_W    = $clog2(NUM_ROWS);

    localparam int LAT_INT  = 1;
    localparam int LAT_MEM  = 1;
    localparam int LAT_ADD  = 1;
    localparam int LAT_MUL  = 3;
    localparam int LAT_DIV  = 4;
    localparam int LAT_MAX  = 4;
    localparam int CNT_W    = $clog2(LAT_MAX + 1);

    typedef enum logic [CLS_W-1:0] {
        CLS_INT = 3'd0,
        CLS_MEM = 3'd1,
        CLS_ADD = 3'd2,
        CLS_MUL = 3'd3,
        CLS_DIV = 3'd4,
        CLS_NONE = 3'd7
    } unit_cls_e;

    typedef enum logic [2:0] {
        WHY_NONE   = 3'd0,
        WHY_UNIT   = 3'd1,
        WHY_RAW    = 3'd2,
        WHY_WAW    = 3'd3,
        WHY_WAR    = 3'd4,
        WHY_WBPORT = 3'd5
    } stall_e;

    typedef struct packed {
        logic             busy;
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] src2;
        logic [CNT_W-1:0] cnt;
    } row_t;

    typedef struct packed {
        logic             valid;
        unit_cls_e        cls;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] src2;
    } req_t;

    function automatic unit_cls_e row_cls(input int idx);
        if (idx < BASE_MEM)      return CLS_INT;
        else if (idx < BASE_ADD) return CLS_MEM;
        else if (idx < BASE_MUL) return CLS_ADD;
        else if (idx < BASE_DIV) return CLS_MUL;
        else if (idx < NUM_ROWS) return CLS_DIV;
        else                     return CLS_NONE;
    endfunction

    function automatic logic [CNT_W-1:0] cls_lat(input unit_cls_e c);
        case (c)
            CLS_INT: return CNT_W'(LAT_INT);
            CLS_MEM: return CNT_W'(LAT_MEM);
            CLS_ADD: return CNT_W'(LAT_ADD);
            CLS_MUL: return CNT_W'(LAT_MUL);
            CLS_DIV: return CNT_W'(LAT_DIV);
            default: return CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/sb_row.sv
module sb_row
    import sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OP_W-1:0]  wr_op,
    input  logic [REG_W-1:0] wr_dst,
    input  logic [REG_W-1:0] wr_src1,
    input  logic [REG_W-1:0] wr_src2,
    input  logic [CNT_W-1:0] wr_lat,
    input  logic             done,
    output row_t             st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (wr_en) begin
            st.busy <= 1'b1;
            st.op   <= wr_op;
            st.dst  <= wr_dst;
            st.src1 <= wr_src1;
            st.src2 <= wr_src2;
            st.cnt  <= wr_lat - CNT_W'(1);
        end else if (done && st.busy) begin
            st <= '0;
        end else if (st.busy && st.cnt != '0) begin
            st.cnt <= st.cnt - CNT_W'(1);
        end
    end

    // R8
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !wr_en && st.busy) |=> !st.busy);

    // R10
    hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (st.busy && !done && !wr_en) |=> st.busy);

    // R10
    op_latch_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (st.busy && st.op == $past(wr_op) && st.dst == $past(wr_dst)));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st.cnt <= CNT_W'(LAT_MAX - 1));

endmodule

// File: rtl/sb_hazard.sv
module sb_hazard
    import sb_pkg::*;
(
    input  logic [NUM_ROWS-1:0]            row_busy,
    input  logic [NUM_ROWS-1:0][REG_W-1:0] row_dst,
    input  logic [NUM_ROWS-1:0][REG_W-1:0] row_src1,
    input  logic [NUM_ROWS-1:0][REG_W-1:0] row_src2,
    input  logic [NUM_ROWS-1:0][CNT_W-1:0] row_cnt,
    input  logic [NUM_ROWS-1:0]            done,
    input  req_t                           req,
    input  logic [CNT_W-1:0]               req_lat,
    output logic                           grant,
    output logic [ROW_W-1:0]               pick,
    output stall_e                         why
);

    logic [NUM_ROWS-1:0] live;
    logic [NUM_ROWS-1:0] free_hit;
    logic [NUM_ROWS-1:0] raw_hit;
    logic [NUM_ROWS-1:0] war_hit;
    logic [NUM_ROWS-1:0] waw_hit;
    logic [NUM_ROWS-1:0] port_hit;

    logic s1_real, s2_real, d_real;
    assign s1_real = (req.src1 != '0);
    assign s2_real = (req.src2 != '0);
    assign d_real  = (req.dst  != '0);

    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_search
        localparam unit_cls_e RC = row_cls(i);
        assign live[i]     = row_busy[i] & ~done[i];
        assign free_hit[i] = (req.cls == RC) & ~live[i];
        assign raw_hit[i]  = live[i] &
                             ((s1_real && req.src1 == row_dst[i]) ||
                              (s2_real && req.src2 == row_dst[i]));
        assign war_hit[i]  = live[i] & d_real &
                             (req.dst == row_src1[i] || req.dst == row_src2[i]);
        assign waw_hit[i]  = live[i] & d_real & (req.dst == row_dst[i]);
        assign port_hit[i] = live[i] & (row_cnt[i] == req_lat);
    end

    logic found;
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_ROWS; i++) begin
            if (free_hit[i] && !found) begin
                pick  = ROW_W'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        if (!req.valid)        why = WHY_NONE;
        else if (!found)       why = WHY_UNIT;
        else if (|raw_hit)     why = WHY_RAW;
        else if (|waw_hit)     why = WHY_WAW;
        else if (|war_hit)     why = WHY_WAR;
        else if (|port_hit)    why = WHY_WBPORT;
        else                   why = WHY_NONE;
        grant = req.valid && (why == WHY_NONE);
    end

endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
    import sb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [CLS_W-1:0]    in_cls,
    input  logic [OP_W-1:0]     in_op,
    input  logic [REG_W-1:0]    in_dst,
    input  logic [REG_W-1:0]    in_src1,
    input  logic [REG_W-1:0]    in_src2,
    input  logic [NUM_ROWS-1:0] wb_done,
    output logic                issue_grant,
    output logic [ROW_W-1:0]    issue_row,
    output logic [2:0]          stall_why
);

    req_t             req;
    logic [CNT_W-1:0] req_lat;
    stall_e           why;

    assign req.valid = in_valid;
    assign req.cls   = unit_cls_e'(in_cls);
    assign req.dst   = in_dst;
    assign req.src1  = in_src1;
    assign req.src2  = in_src2;
    assign req_lat   = cls_lat(req.cls);

    row_t                           rows [NUM_ROWS];
    logic [NUM_ROWS-1:0]            row_busy;
    logic [NUM_ROWS-1:0][REG_W-1:0] row_dst;
    logic [NUM_ROWS-1:0][REG_W-1:0] row_src1;
    logic [NUM_ROWS-1:0][REG_W-1:0] row_src2;
    logic [NUM_ROWS-1:0][CNT_W-1:0] row_cnt;

    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
        sb_row u_row (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (issue_grant && issue_row == ROW_W'(i)),
            .wr_op   (in_op),
            .wr_dst  (in_dst),
            .wr_src1 (in_src1),
            .wr_src2 (in_src2),
            .wr_lat  (req_lat),
            .done    (wb_done[i]),
            .st      (rows[i])
        );
        assign row_busy[i] = rows[i].busy;
        assign row_dst[i]  = rows[i].dst;
        assign row_src1[i] = rows[i].src1;
        assign row_src2[i] = rows[i].src2;
        assign row_cnt[i]  = rows[i].cnt;
    end

    sb_hazard u_hazard (
        .row_busy (row_busy),
        .row_dst  (row_dst),
        .row_src1 (row_src1),
        .row_src2 (row_src2),
        .row_cnt  (row_cnt),
        .done     (wb_done),
        .req      (req),
        .req_lat  (req_lat),
        .grant    (issue_grant),
        .pick     (issue_row),
        .why      (why)
    );

    assign stall_why = why;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> (!issue_grant && stall_why == 3'd0));

    // R2
    row_class_chk: assert property (@(posedge clk) disable iff (rst)
        issue_grant |-> (row_cls(int'(issue_row)) == unit_cls_e'(in_cls)));

    // R3
    grant_free_chk: assert property (@(posedge clk) disable iff (rst)
        issue_grant |-> (!row_busy[issue_row] || wb_done[issue_row]));

    // R10
    grant_fills_chk: assert property (@(posedge clk) disable iff (rst)
        issue_grant |=> row_busy[$past(issue_row)]);

endmodule

// File: tb/sb_issue_ctl_tb_top.sv
module sb_issue_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [2:0] in_cls = '0;
    logic [5:0] in_op = '0;
    logic [4:0] in_dst = '0;
    logic [4:0] in_src1 = '0;
    logic [4:0] in_src2 = '0;
    logic [7:0] wb_done = '0;
    logic       issue_grant;
    logic [2:0] issue_row;
    logic [2:0] stall_why;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic       g_s;
    logic [2:0] r_s;
    logic [2:0] w_s;

    localparam logic [2:0] C_INT = 3'd0, C_MEM = 3'd1, C_ADD = 3'd2,
                           C_MUL = 3'd3, C_DIV = 3'd4;
    localparam logic [2:0] W_NONE = 3'd0, W_UNIT = 3'd1, W_RAW = 3'd2,
                           W_WAW = 3'd3, W_WAR = 3'd4, W_PORT = 3'd5;

    always #4 clk = ~clk;

    sb_issue_ctl dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
        .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .wb_done(wb_done), .issue_grant(issue_grant), .issue_row(issue_row),
        .stall_why(stall_why)
    );

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; wb_done = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic v, input logic [2:0] c, input logic [4:0] d,
                        input logic [4:0] s1, input logic [4:0] s2, input logic [7:0] dn);
        @(negedge clk);
        in_valid = v; in_cls = c; in_op = {1'b0, d}; in_dst = d;
        in_src1 = s1; in_src2 = s2; wb_done = dn;
        #1;
        g_s = issue_grant; r_s = issue_row; w_s = stall_why;
    endtask

    task automatic check(input string tag, input logic eg, input logic [2:0] er,
                         input logic [2:0] ew);
        n_total++;
        if (g_s !== eg || w_s !== ew || (eg && r_s !== er)) begin
            n_fail++;
            $display("FAIL %s: grant=%0b row=%0d why=%0d expected grant=%0b row=%0d why=%0d",
                     tag, g_s, r_s, w_s, eg, er, ew);
        end
    endtask

    task automatic t_reset();
        do_reset();
        step(1'b0, C_INT, 5'd3, 5'd0, 5'd0, 8'h00);
        check("R1 idle after reset", 1'b0, 3'd0, W_NONE);
        step(1'b1, C_INT, 5'd3, 5'd0, 5'd0, 8'h00);
        check("R2 int to row0", 1'b1, 3'd0, W_NONE);
        step(1'b1, C_INT, 5'd4, 5'd0, 5'd0, 8'h00);
        check("R10 row0 still busy", 1'b0, 3'd0, W_UNIT);
        do_reset();
        step(1'b1, C_INT, 5'd4, 5'd0, 5'd0, 8'h00);
        check("R1 reset empties table", 1'b1, 3'd0, W_NONE);
        step(1'b1, 3'd6, 5'd9, 5'd0, 5'd0, 8'h00);
        check("R3 class without rows", 1'b0, 3'd0, W_UNIT);
    endtask

    task automatic t_alloc();
        do_reset();
        step(1'b1, C_ADD, 5'd1, 5'd0, 5'd0, 8'h00);
        check("R2 first add row2", 1'b1, 3'd2, W_NONE);
        step(1'b1, C_ADD, 5'd2, 5'd0, 5'd0, 8'h00);
        check("R2 second add row3", 1'b1, 3'd3, W_NONE);
        step(1'b1, C_ADD, 5'd3, 5'd0, 5'd0, 8'h00);
        check("R2 third add row4", 1'b1, 3'd4, W_NONE);
        step(1'b1, C_ADD, 5'd4, 5'd0, 5'd0, 8'h00);
        check("R3 adders full", 1'b0, 3'd0, W_UNIT);
        step(1'b0, C_ADD, 5'd4, 5'd0, 5'd0, 8'h08);
        check("R1 idle during done", 1'b0, 3'd0, W_NONE);
        step(1'b1, C_ADD, 5'd4, 5'd0, 5'd0, 8'h00);
        check("R8 freed row3 reused", 1'b1, 3'd3, W_NONE);
        step(1'b1, C_ADD, 5'd5, 5'd0, 5'd0, 8'h04);
        check("R8 same-cycle reissue row2", 1'b1, 3'd2, W_NONE);
        step(1'b1, C_MUL, 5'd6, 5'd0, 5'd0, 8'h40);
        check("R8 done on idle row ignored", 1'b1, 3'd5, W_NONE);
        step(1'b1, C_MUL, 5'd7, 5'd0, 5'd0, 8'h00);
        check("R2 second mul row6", 1'b1, 3'd6, W_NONE);
    endtask

    task automatic t_raw();
        do_reset();
        step(1'b1, C_INT, 5'd7, 5'd0, 5'd0, 8'h00);
        check("R4 producer", 1'b1, 3'd0, W_NONE);
        step(1'b1, C_MUL, 5'd8, 5'd7, 5'd0, 8'h00);
        check("R4 src1 raw", 1'b0, 3'd0, W_RAW);
        step(1'b1, C_MUL, 5'd8, 5'd0, 5'd7, 8'h00);
        check("R4 src2 raw", 1'b0, 3'd0, W_RAW);
        step(1'b1, C_MUL, 5'd8, 5'd7, 5'd0, 8'h01);
        check("R8 raw cleared same cycle", 1'b1, 3'd5, W_NONE);
    endtask

    task automatic t_war();
        do_reset();
        step(1'b1, C_MEM, 5'd9, 5'd10, 5'd11, 8'h00);
        check("R2 mem row1", 1'b1, 3'd1, W_NONE);
        step(1'b1, C_ADD, 5'd11, 5'd0, 5'd0, 8'h00);
        check("R5 war on src2", 1'b0, 3'd0, W_WAR);
        step(1'b1, C_ADD, 5'd10, 5'd0, 5'd0, 8'h00);
        check("R5 war on src1", 1'b0, 3'd0, W_WAR);
    endtask

    task automatic t_waw();
        do_reset();
        step(1'b1, C_INT, 5'd12, 5'd13, 5'd0, 8'h00);
        check("R6 producer", 1'b1, 3'd0, W_NONE);
        step(1'b1, C_ADD, 5'd12, 5'd0, 5'd0, 8'h00);
        check("R6 waw", 1'b0, 3'd0, W_WAW);
        step(1'b1, C_ADD, 5'd12, 5'd12, 5'd0, 8'h00);
        check("R6 raw outranks waw", 1'b0, 3'd0, W_RAW);
        step(1'b1, C_ADD, 5'd13, 5'd0, 5'd0, 8'h00);
        check("R6 war alone", 1'b0, 3'd0, W_WAR);
        step(1'b1, C_INT, 5'd12, 5'd12, 5'd0, 8'h00);
        check("R6 unit outranks raw", 1'b0, 3'd0, W_UNIT);
    endtask

    task automatic t_zero();
        do_reset();
        step(1'b1, C_INT, 5'd0, 5'd0, 5'd0, 8'h00);
        check("R7 no-dest int", 1'b1, 3'd0, W_NONE);
        step(1'b1, C_ADD, 5'd0, 5'd0, 5'd0, 8'h00);
        check("R7 zero fields never match", 1'b1, 3'd2, W_NONE);
    endtask

    task automatic t_port();
        do_reset();
        step(1'b1, C_MUL, 5'd1, 5'd0, 5'd0, 8'h00);
        check("R9 mul issue", 1'b1, 3'd5, W_NONE);
        step(1'b1, C_INT, 5'd2, 5'd0, 5'd0, 8'h00);
        check("R9 int before collision", 1'b1, 3'd0, W_NONE);
        step(1'b1, C_ADD, 5'd3, 5'd0, 5'd0, 8'h00);
        check("R9 add collides with mul", 1'b0, 3'd0, W_PORT);
        step(1'b1, C_ADD, 5'd3, 5'd0, 5'd0, 8'h00);
        check("R9 add one cycle later", 1'b1, 3'd2, W_NONE);
        do_reset();
        step(1'b1, C_DIV, 5'd1, 5'd0, 5'd0, 8'h00);
        check("R9 div issue", 1'b1, 3'd7, W_NONE);
        step(1'b1, C_MUL, 5'd2, 5'd0, 5'd0, 8'h00);
        check("R9 mul collides with div", 1'b0, 3'd0, W_PORT);
        step(1'b1, C_DIV, 5'd3, 5'd0, 5'd0, 8'h00);
        check("R3 divider unpipelined", 1'b0, 3'd0, W_UNIT);
        step(1'b1, C_DIV, 5'd3, 5'd0, 5'd0, 8'h80);
        check("R8 divider reissue on done", 1'b1, 3'd7, W_NONE);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_alloc();
        t_raw();
        t_war();
        t_waw();
        t_zero();
        t_port();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule